// File: doc/BRIEF.md
# Fractional-Nanosecond Time Counter

This block keeps a free-running time of day for precision timestamping. Every cycle of the core clock, while it is enabled, it adds a programmable increment to a 96-bit accumulator. The increment is 32.32 fixed point: 32 bits of whole nanoseconds and 32 bits of fractional nanoseconds. The accumulator holds a 64-bit nanosecond count and a 32-bit fraction. Software trims the clock rate at run time by rewriting the increment. For a core clock of F Hz the nominal increment is (10^9 × 2^32) / F. At 50 MHz that is 20 ns, written 0x0000_0014_0000_0000.

Software reaches the counter through a small port of 64-bit registers with a 12-bit byte address, which accepts one request per cycle. The port has an enable register, an increment register, and two time registers that can be read and loaded: the nanosecond register and the fraction register. Reading the fraction register captures the matching nanosecond value. The next nanosecond read then returns a pair that belongs to the same instant, even though the counter keeps moving.

Top module: `fracns_clock`

## Requirements
- R1: After reset the enable bit, the increment, the nanosecond count and the fraction are all zero, so every time register reads 0 and the count stays still.
- R2: Bit 0 of the register at byte address 0xF00 enables counting. The register reads back as that bit alone, with bits 63:1 zero. While the bit is 0 the time does not change.
- R3: On each enabled cycle without a load, the 96-bit value {nanoseconds, fraction} grows by the zero-extended 64-bit increment. A carry out of the fraction reaches the nanosecond count in the same cycle.
- R4: The nanosecond count wraps modulo 2^64.
- R5: A write to 0xF18 sets the increment, which reads back from that address. The write cycle still adds the old increment, the new one is used from the next cycle on, and the accumulated time is kept.
- R6: A write to 0xF10 loads the nanosecond count from data bits 63:0, and a write to 0xF08 loads the fraction from data bits 31:0. In the load cycle nothing is added, and the part that was not written keeps its value.
- R7: A read of 0xF08 returns the fraction in bits 31:0 with the upper bits zero, and captures the nanosecond count of that same instant. The next read of 0xF10 returns the captured value. A read of 0xF10 with no read of 0xF08 since the previous read of 0xF10 returns the live count.
- R8: A read of any other address, including a misaligned one, returns 0. A write to any other address changes nothing.
- R9: req_ready is always 1. A read accepted on a clock edge gives rsp_valid=1 on the following cycle, with register values as they were just before that edge. In every other cycle, including after writes, rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, and the counting tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |

## Verification
The bench sweeps every one of the 4096 addresses for reads. It then writes all-ones to every unmapped address and checks that no register changed. A decoder that aliased or ignored address bits would show nonzero data or a corrupted register. It runs the counter with increments that carry out of the fraction, with a whole-nanosecond-only increment, and across the 2^64 nanosecond boundary. A missing carry, a truncated nanosecond count or a broken wrap shows up as a wrong difference between two coherent samples. Further cases change the increment mid-run, load each time register while counting, and read the nanosecond register alone after a captured pair. A design that reset the time on an increment write, added during a load, or returned a stale capture would give the wrong value in one of these.

// File: rtl/fracns_pkg.sv
package fracns_pkg;
   localparam int OFS_CFG  = 0;
   localparam int OFS_FRAC = 8;
   localparam int OFS_NS   = 16;
   localparam int OFS_COMP = 24;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CFG,
      SEL_FRAC,
      SEL_NS,
      SEL_COMP
   } reg_sel_e;
endpackage

// File: rtl/fracns_regfile.sv
module fracns_regfile
   import fracns_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 64,
   parameter int BASE_ADDR = 'hF00,
   parameter int NS_W      = 64,
   parameter int FRAC_W    = 32,
   parameter int CW        = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [FRAC_W-1:0] frac_in,
   input  logic [NS_W-1:0]   ns_rd_in,
   output logic              clk_en,
   output logic [CW-1:0]     comp,
   output logic              ld_frac,
   output logic              ld_ns,
   output logic              rd_frac,
   output logic              rd_ns,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(BASE_ADDR + OFS_CFG);
   localparam logic [ADDR_W-1:0] A_FRAC = ADDR_W'(BASE_ADDR + OFS_FRAC);
   localparam logic [ADDR_W-1:0] A_NS   = ADDR_W'(BASE_ADDR + OFS_NS);
   localparam logic [ADDR_W-1:0] A_COMP = ADDR_W'(BASE_ADDR + OFS_COMP);

   reg_sel_e          sel;
   logic              wr, rd;
   logic              en_q;
   logic [CW-1:0]     comp_q;
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      sel = SEL_NONE;
      if (req_addr == A_CFG)  sel = SEL_CFG;
      if (req_addr == A_FRAC) sel = SEL_FRAC;
      if (req_addr == A_NS)   sel = SEL_NS;
      if (req_addr == A_COMP) sel = SEL_COMP;
   end

   assign wr      = req_valid &  req_write;
   assign rd      = req_valid & ~req_write;
   assign ld_frac = wr && (sel == SEL_FRAC);
   assign ld_ns   = wr && (sel == SEL_NS);
   assign rd_frac = rd && (sel == SEL_FRAC);
   assign rd_ns   = rd && (sel == SEL_NS);

   always_comb begin
      unique case (sel)
         SEL_CFG:  rd_mux = DATA_W'(en_q);
         SEL_FRAC: rd_mux = DATA_W'(frac_in);
         SEL_NS:   rd_mux = DATA_W'(ns_rd_in);
         SEL_COMP: rd_mux = DATA_W'(comp_q);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         comp_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         if (wr && sel == SEL_CFG)  en_q   <= req_wdata[0];
         if (wr && sel == SEL_COMP) comp_q <= req_wdata[CW-1:0];
         rsp_valid <= rd;
         if (rd) rsp_rdata <= rd_mux;
      end
   end

   logic unused_wd;
   assign unused_wd = ^req_wdata;

   assign clk_en = en_q;
   assign comp   = comp_q;
endmodule

// File: rtl/fracns_accum.sv
module fracns_accum #(
   parameter int NS_W   = 64,
   parameter int FRAC_W = 32,
   parameter int CW     = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [CW-1:0]     comp,
   input  logic              ld_frac,
   input  logic              ld_ns,
   input  logic [FRAC_W-1:0] ld_frac_val,
   input  logic [NS_W-1:0]   ld_ns_val,
   output logic [NS_W-1:0]   ns,
   output logic [FRAC_W-1:0] frac
);
   localparam int AW = NS_W + FRAC_W;

   logic [AW-1:0] acc_q;
   logic [AW-1:0] sum;

   assign sum = acc_q + AW'(comp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (ld_ns || ld_frac) begin
         if (ld_ns)   acc_q[AW-1:FRAC_W]  <= ld_ns_val;
         if (ld_frac) acc_q[FRAC_W-1:0]   <= ld_frac_val;
      end else if (en) begin
         acc_q <= sum;
      end
   end

   assign ns   = acc_q[AW-1:FRAC_W];
   assign frac = acc_q[FRAC_W-1:0];
endmodule

// File: rtl/fracns_snap.sv
module fracns_snap #(
   parameter int NS_W       = 64,
   parameter bit USE_SHADOW = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_frac,
   input  logic            rd_ns,
   input  logic [NS_W-1:0] ns_live,
   output logic [NS_W-1:0] ns_rd
);
   generate
      if (USE_SHADOW) begin : g_shadow
         logic [NS_W-1:0] shadow_q;
         logic            armed_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow_q <= '0;
               armed_q  <= 1'b0;
            end else if (rd_frac) begin
               shadow_q <= ns_live;
               armed_q  <= 1'b1;
            end else if (rd_ns) begin
               armed_q  <= 1'b0;
            end
         end
         assign ns_rd = armed_q ? shadow_q : ns_live;
      end else begin : g_live
         logic unused_snap;
         assign unused_snap = clk ^ rst_n ^ rd_frac ^ rd_ns;
         assign ns_rd = ns_live;
      end
   endgenerate
endmodule

// File: rtl/fracns_clock.sv
module fracns_clock #(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 64,
   parameter int BASE_ADDR  = 'hF00,
   parameter int NS_W       = 64,
   parameter int FRAC_W     = 32,
   parameter int INT_W      = 32,
   parameter bit USE_SHADOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   localparam int CW = INT_W + FRAC_W;

   generate
      if (NS_W > DATA_W || CW > DATA_W)
         $error("fracns_clock: register fields wider than data path");
      if (INT_W > NS_W || FRAC_W < 1)
         $error("fracns_clock: bad increment split");
      if (BASE_ADDR + 24 >= (1 << ADDR_W))
         $error("fracns_clock: register window outside address space");
   endgenerate

   logic              en_w;
   logic [CW-1:0]     comp_w;
   logic              ld_frac_w, ld_ns_w, rd_frac_w, rd_ns_w;
   logic [NS_W-1:0]   ns_w, ns_rd_w;
   logic [FRAC_W-1:0] frac_w;

   assign req_ready = 1'b1;

   fracns_regfile #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
      .NS_W(NS_W), .FRAC_W(FRAC_W), .CW(CW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .frac_in(frac_w), .ns_rd_in(ns_rd_w),
      .clk_en(en_w), .comp(comp_w),
      .ld_frac(ld_frac_w), .ld_ns(ld_ns_w),
      .rd_frac(rd_frac_w), .rd_ns(rd_ns_w),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   fracns_accum #(.NS_W(NS_W), .FRAC_W(FRAC_W), .CW(CW)) u_acc (
      .clk(clk), .rst_n(rst_n), .en(en_w), .comp(comp_w),
      .ld_frac(ld_frac_w), .ld_ns(ld_ns_w),
      .ld_frac_val(req_wdata[FRAC_W-1:0]), .ld_ns_val(req_wdata[NS_W-1:0]),
      .ns(ns_w), .frac(frac_w)
   );

   fracns_snap #(.NS_W(NS_W), .USE_SHADOW(USE_SHADOW)) u_snap (
      .clk(clk), .rst_n(rst_n), .rd_frac(rd_frac_w), .rd_ns(rd_ns_w),
      .ns_live(ns_w), .ns_rd(ns_rd_w)
   );
endmodule

// File: rtl/fracns_chk.sv
module fracns_chk #(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 64,
   parameter int BASE_ADDR = 'hF00,
   parameter int NS_W      = 64,
   parameter int FRAC_W    = 32,
   parameter int CW        = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_wdata,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              en,
   input logic [CW-1:0]     comp,
   input logic [NS_W-1:0]   ns,
   input logic [FRAC_W-1:0] frac,
   input logic              ld_any
);
   localparam int AW = NS_W + FRAC_W;
   logic rd_req, unmapped;
   assign rd_req   = req_valid && !req_write;
   assign unmapped = (req_addr != ADDR_W'(BASE_ADDR))      && (req_addr != ADDR_W'(BASE_ADDR + 8)) &&
                     (req_addr != ADDR_W'(BASE_ADDR + 16)) && (req_addr != ADDR_W'(BASE_ADDR + 24));

   always @(posedge clk)
      if (!rst_n)
         a_r1_reset_clear: assert (!en && comp == '0 && ns == '0 && frac == '0);

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !ld_any) |=> ({ns, frac} == $past({ns, frac})));

   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !ld_any) |=> ({ns, frac} == $past({ns, frac}) + AW'($past(comp))));

   a_r5_comp_load: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == ADDR_W'(BASE_ADDR + 24))
      |=> (comp == $past(req_wdata[CW-1:0])));

   a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && unmapped) |=> (rsp_rdata == '0));

   a_r9_read_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rsp_valid);

   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rsp_valid);
endmodule

bind fracns_clock fracns_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
   .NS_W(NS_W), .FRAC_W(FRAC_W), .CW(INT_W + FRAC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .req_wdata(req_wdata),
   .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
   .en(en_w), .comp(comp_w), .ns(ns_w), .frac(frac_w),
   .ld_any(ld_frac_w | ld_ns_w)
);

// File: tb/sim_fracns_clock.sv
module sim_fracns_clock;
   localparam logic [11:0] A_CFG  = 12'hF00;
   localparam logic [11:0] A_FRAC = 12'hF08;
   localparam logic [11:0] A_NS   = 12'hF10;
   localparam logic [11:0] A_COMP = 12'hF18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [63:0] rsp_rdata;
   int          checks = 0, failures = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   fracns_clock u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [63:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      chk("R9 no response to write", 96'(rsp_valid), 96'(0));
   endtask

   task automatic rd(input logic [11:0] a, output logic [63:0] d);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
      @(negedge clk);
      req_valid = 1'b0;
      if (!rsp_valid) chk("R9 read response valid", 96'(rsp_valid), 96'(1));
      d = rsp_rdata;
   endtask

   // frac read then ns read: one coherent {ns,frac} pair
   task automatic sample(output logic [95:0] v);
      logic [63:0] f, n;
      rd(A_FRAC, f);
      rd(A_NS, n);
      chk("R7 frac upper bits zero", 96'(f[63:32]), 96'(0));
      v = {n, f[31:0]};
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [63:0] map_val(input logic [11:0] a, input logic [63:0] cfg,
         input logic [63:0] fr, input logic [63:0] ns, input logic [63:0] cp);
      case (a)
         A_CFG:   return cfg;
         A_FRAC:  return fr;
         A_NS:    return ns;
         A_COMP:  return cp;
         default: return 64'd0;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [63:0] d, d2;
      logic [95:0] v, v2, exp;
      logic [63:0] comps [4];
      logic [63:0] ns0s  [4];
      logic [31:0] fr0s  [4];

      #1 rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state, R9 ready
      chk("R9 req_ready high", 96'(req_ready), 96'(1));
      rd(A_CFG, d);  chk("R1 cfg after reset", 96'(d), 96'(0));
      rd(A_COMP, d); chk("R1 comp after reset", 96'(d), 96'(0));
      idle(5);
      sample(v);     chk("R1 time stopped at zero", v, 96'(0));
      idle(1);
      chk("R9 rsp_valid drops", 96'(rsp_valid), 96'(0));

      // R8 exhaustive read sweep with known register contents
      wr(A_COMP, 64'h1234_5678_9ABC_DEF0);
      wr(A_NS,   64'hCAFE_0000_1111_2222);
      wr(A_FRAC, 64'hFFFF_FFFF_8765_4321);
      for (int a = 0; a < 4096; a++) begin
         rd(12'(a), d);
         chk($sformatf("R8 read sweep addr %h", a[11:0]), 96'(d),
             96'(map_val(12'(a), 64'd0, 64'h8765_4321, 64'hCAFE_0000_1111_2222, 64'h1234_5678_9ABC_DEF0)));
      end
      // R8 writes to unmapped addresses change nothing
      for (int a = 0; a < 4096; a++) begin
         if (map_val(12'(a), 64'd1, 64'd1, 64'd1, 64'd1) == 64'd0)
            wr(12'(a), '1);
      end
      rd(A_CFG, d);  chk("R8 cfg after unmapped writes", 96'(d), 96'(0));
      rd(A_COMP, d); chk("R8 comp after unmapped writes", 96'(d), 96'(64'h1234_5678_9ABC_DEF0));
      sample(v);     chk("R8 time after unmapped writes", v, {64'hCAFE_0000_1111_2222, 32'h8765_4321});

      // R2 cfg readback shows bit 0 only
      wr(A_CFG, '1);
      rd(A_CFG, d); chk("R2 cfg readback", 96'(d), 96'(1));
      wr(A_CFG, 64'hFFFF_FFFF_FFFF_FFFE);
      rd(A_CFG, d); chk("R2 cfg cleared by bit0=0", 96'(d), 96'(0));

      // R3/R4 stepping under several increments
      comps[0] = 64'h0000_0014_0000_0000; ns0s[0] = 64'd1000;                fr0s[0] = 32'd0;
      comps[1] = 64'h0000_0000_8000_0001; ns0s[1] = 64'd7;                   fr0s[1] = 32'hFFFF_FFF0;
      comps[2] = 64'h0000_0013_FFFF_FFFF; ns0s[2] = 64'h0000_0001_FFFF_FFF0; fr0s[2] = 32'h0000_0002;
      comps[3] = 64'h0000_0002_8000_0000; ns0s[3] = 64'hFFFF_FFFF_FFFF_FFFB; fr0s[3] = 32'hC000_0000;
      for (int i = 0; i < 4; i++) begin
         string tag;
         tag = (i == 3) ? "R4 wrap" : "R3 step";
         wr(A_CFG, 64'd0);
         wr(A_COMP, comps[i]);
         wr(A_NS, ns0s[i]);
         wr(A_FRAC, {32'hA5A5_A5A5, fr0s[i]});
         wr(A_CFG, 64'd1);
         sample(v);
         chk($sformatf("%s load start %0d", tag, i), v, {ns0s[i], fr0s[i]});
         for (int k = 0; k < 9; k += 4) begin
            idle(k);
            sample(v2);
            exp = v + 96'(k + 2) * 96'(comps[i]);
            chk($sformatf("%s comp=%h k=%0d", tag, comps[i], k), v2, exp);
            v = v2;
         end
      end

      // R5 increment change mid-run keeps time
      wr(A_CFG, 64'd0);
      wr(A_COMP, 64'h0000_0003_4000_0000);
      wr(A_NS, 64'd500);
      wr(A_FRAC, 64'd0);
      wr(A_CFG, 64'd1);
      sample(v);
      wr(A_COMP, 64'h0000_0007_0000_0001);
      sample(v2);
      chk("R5 old increment used through write cycle", v2, v + 96'(3) * 96'(64'h0000_0003_4000_0000));
      sample(v);
      chk("R5 new increment from next cycle", v, v2 + 96'(2) * 96'(64'h0000_0007_0000_0001));
      rd(A_COMP, d); chk("R5 comp readback", 96'(d), 96'(64'h0000_0007_0000_0001));

      // R6 loads replace the addition
      sample(v);
      wr(A_NS, 64'h0123_4567_89AB_CDEF);
      sample(v2);
      exp = v + 96'(2) * 96'(64'h0000_0007_0000_0001);
      chk("R6 ns load, frac held", v2, {64'h0123_4567_89AB_CDEF, exp[31:0]});
      sample(v);
      wr(A_FRAC, 64'h0000_0000_0BAD_F00D);
      sample(v2);
      exp = v + 96'(2) * 96'(64'h0000_0007_0000_0001);
      chk("R6 frac load, ns held", v2, {exp[95:32], 32'h0BAD_F00D});

      // R2 hold when disabled
      sample(v);
      wr(A_CFG, 64'd0);
      idle(6);
      sample(v2);
      chk("R2 held while disabled", v2, v + 96'(3) * 96'(64'h0000_0007_0000_0001));
      idle(3);
      sample(v);
      chk("R2 still held", v, v2);

      // R7 shadow versus live
      wr(A_COMP, 64'h0000_0001_0000_0000);
      wr(A_NS, 64'd100);
      wr(A_FRAC, 64'd0);
      wr(A_CFG, 64'd1);
      rd(A_FRAC, d);
      idle(3);
      rd(A_NS, d);
      chk("R7 captured ns after delay", 96'(d), 96'(100));
      rd(A_NS, d2);
      chk("R7 second ns read is live", 96'(d2), 96'(105));
      rd(A_NS, d2);
      chk("R7 plain ns read is live", 96'(d2), 96'(106));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule